// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block is a bus master. It runs one command exchange with a management microcontroller through a mailbox of three 32-bit registers: message, argument and response. A requester pulses `req_start` and supplies an 8-bit message code, a 32-bit argument, a flag asking for returned data, and a port select. The port select picks one of two register banks. The sequencer first polls the response register until it reads nonzero, which shows that the previous exchange has finished. It then clears the response register, loads the argument and writes the message code. After that it polls the response register again until the microcontroller answers.

The answer is sorted into a result class. When the command succeeds and data was asked for, the block waits a configurable hold-off and then reads the argument register back as the returned data. Each poll has a read spacing and a read budget. All time values are given in microseconds and converted to clock cycles with a cycles-per-microsecond parameter. Completion is signalled by a one-cycle `req_done` pulse, with status and data valid in that cycle.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, `req_busy`, `req_done` and `bus_valid` are low, and `req_status` and `req_data` are zero.
- R2: After a start, the first bus access is a read of the response register. While that read returns zero, the read is repeated at least POLL_GAP_US*CYC_PER_US cycles after the previous one. No write is issued until a nonzero value has been read.
- R3: After the first nonzero response, exactly three writes follow, in this order:
  - zero to the response register;
  - the request argument to the argument register;
  - the message code, zero-extended to 32 bits, to the message register.
- R4: After the message write, the response register is polled again with the same spacing until it reads nonzero.
- R5: If either poll reads zero POLL_LIMIT times, the command ends with status 4 (timeout). No further bus access is made, and no decode takes place.
- R6: The final response is decoded as follows:
  - 0x01 gives status 0 (success);
  - 0xFC gives status 1 (rejected, busy);
  - 0xFE gives status 2 (unknown command);
  - 0xFD, 0xFF and any other nonzero value give status 3 (I/O failure).
- R7: On success with data requested, the argument register is read no earlier than READBACK_US*CYC_PER_US cycles after the answering response read. The value read appears on `req_data`.
- R8: The port select is captured at start and sets the register offsets:
  - port 0: message 0x538, argument 0x9BC, response 0x980;
  - port 1: message 0xA20, argument 0xA88, response 0xA80.
- R9: `req_busy` is high from the cycle after an accepted start until the cycle after `req_done`. A start pulse while busy is ignored and causes no bus access.
- R10: `req_done` is high for exactly one cycle per command. `req_data` is zero unless the command succeeded with data requested.
- R11: A bus access holds `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` steady until `bus_ready` is seen high. The access completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle command start |
| req_msg | input | 8 | Message code |
| req_arg | input | 32 | Argument value |
| req_want_data | input | 1 | Read back returned data on success |
| req_alt_port | input | 1 | Select the alternate register bank |
| req_busy | output | 1 | Command in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_status | output | 3 | Result class (0 ok, 1 busy, 2 unknown, 3 I/O failure, 4 timeout) |
| req_data | output | 32 | Returned data |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 12 | Register offset |
| bus_wdata | output | 32 | Write data |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |

## Verification
The bench targets each of these corner cases and states what a faulty design would show:

- **Poll boundaries.** Zero responses before and after the message write, with the read budget running out in each poll. An off-by-one budget shows up as a wrong count of response reads. A missing pre-poll timeout shows up as stray writes after the timeout.
- **Write order and data.** The order of the three writes and the zero-extension of the message. Swapped writes, or a wrong bank after a port switch, show up as unexpected addresses or data.
- **Read-back path.** A shortened read-back wait shows up as too small a cycle distance before the argument read. Data leaking on failure or no-data requests shows up as a nonzero `req_data`.
- **Decode and start handling.** Each response class, including an unlisted nonzero code, must land in its own status. A start pulse while busy must not launch a second exchange.

// File: rtl/mbox_pkg.sv
// Shared types and constants for the mailbox command sequencer.
// Assumes 12-bit register offsets within the mailbox window.
package mbox_pkg;

    localparam int OFS_W = 12;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_BUSY    = 3'd1,
        ST_UNKNOWN = 3'd2,
        ST_IOERR   = 3'd3,
        ST_TIMEOUT = 3'd4
    } result_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_GAP,
        S_CLR_WR,
        S_ARG_WR,
        S_MSG_WR,
        S_POST_RD,
        S_POST_GAP,
        S_HOLD,
        S_DATA_RD,
        S_FINISH
    } seq_state_t;

    // Primary bank offsets.
    localparam logic [OFS_W-1:0] P0_MSG  = 12'h538;
    localparam logic [OFS_W-1:0] P0_ARG  = 12'h9BC;
    localparam logic [OFS_W-1:0] P0_RESP = 12'h980;

    // Alternate bank offsets.
    localparam logic [OFS_W-1:0] P1_MSG  = 12'hA20;
    localparam logic [OFS_W-1:0] P1_ARG  = 12'hA88;
    localparam logic [OFS_W-1:0] P1_RESP = 12'hA80;

endpackage

// File: rtl/mbox_port_map.sv
// Maps the captured port select onto the three mailbox register offsets.
// Purely combinational; assumes the select is stable for a whole command.
module mbox_port_map
    import mbox_pkg::*;
(
    input  logic             alt,
    output logic [OFS_W-1:0] msg_ofs,
    output logic [OFS_W-1:0] arg_ofs,
    output logic [OFS_W-1:0] resp_ofs
);

    // Pick the bank offsets for the selected port.
    always_comb begin
        if (alt) begin
            msg_ofs  = P1_MSG;
            arg_ofs  = P1_ARG;
            resp_ofs = P1_RESP;
        end else begin
            msg_ofs  = P0_MSG;
            arg_ofs  = P0_ARG;
            resp_ofs = P0_RESP;
        end
    end

endmodule

// File: rtl/mbox_decode.sv
// Sorts a nonzero response word into a result class.
// Assumes it is only consulted when the response is nonzero.
module mbox_decode
    import mbox_pkg::*;
(
    input  logic [31:0] resp,
    output result_t     cls
);

    // Map known codes; everything else is an I/O failure.
    always_comb begin
        unique case (resp)
            32'h01:  cls = ST_OK;
            32'hFC:  cls = ST_BUSY;
            32'hFE:  cls = ST_UNKNOWN;
            default: cls = ST_IOERR;
        endcase
    end

endmodule

// File: rtl/mbox_timer.sv
// Down-counter used for poll spacing and the read-back hold-off.
// Loading sets the count; expired is high once the count has reached zero.
module mbox_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/mbox_cmd_seq.sv
// Mailbox command sequencer: one command exchange per start pulse.
// Flow: pre-poll of response, clear response, write argument, write message,
// post-poll of response, decode, and an optional delayed argument read-back.
// Assumes a valid/ready register bus where ready completes the access.
module mbox_cmd_seq
    import mbox_pkg::*;
#(
    parameter int CYC_PER_US  = 125,
    parameter int POLL_GAP_US = 50,
    parameter int POLL_LIMIT  = 20000,
    parameter int READBACK_US = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic [7:0]  req_msg,
    input  logic [31:0] req_arg,
    input  logic        req_want_data,
    input  logic        req_alt_port,
    output logic        req_busy,
    output logic        req_done,
    output logic [2:0]  req_status,
    output logic [31:0] req_data,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [11:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ready,
    input  logic [31:0] bus_rdata
);

    localparam int GAP_CYC = POLL_GAP_US * CYC_PER_US;
    localparam int RB_CYC  = READBACK_US * CYC_PER_US;
    localparam int MAX_CYC = (GAP_CYC > RB_CYC) ? GAP_CYC : RB_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam int PW      = $clog2(POLL_LIMIT + 1);

    seq_state_t        state;
    logic [7:0]        msg_q;
    logic [31:0]       arg_q;
    logic              want_q;
    logic              alt_q;
    logic [PW-1:0]     poll_cnt;
    result_t           status_q;
    logic [31:0]       data_q;

    logic [OFS_W-1:0]  msg_ofs, arg_ofs, resp_ofs;
    result_t           resp_cls;
    logic              acc;
    logic              resp_zero;
    logic              last_poll;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;

    mbox_port_map u_map (
        .alt      (alt_q),
        .msg_ofs  (msg_ofs),
        .arg_ofs  (arg_ofs),
        .resp_ofs (resp_ofs)
    );

    mbox_decode u_dec (
        .resp (bus_rdata),
        .cls  (resp_cls)
    );

    mbox_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Bus request outputs derived from the current state.
    always_comb begin
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = resp_ofs;
        bus_wdata = '0;
        unique case (state)
            S_PRE_RD, S_POST_RD: bus_valid = 1'b1;
            S_CLR_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
            end
            S_ARG_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = arg_ofs;
                bus_wdata = arg_q;
            end
            S_MSG_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = msg_ofs;
                bus_wdata = {24'd0, msg_q};
            end
            S_DATA_RD: begin
                bus_valid = 1'b1;
                bus_addr  = arg_ofs;
            end
            default: ;
        endcase
    end

    assign acc       = bus_valid && bus_ready;
    assign resp_zero = (bus_rdata == 32'd0);
    assign last_poll = (poll_cnt == PW'(POLL_LIMIT - 1));

    // Timer loads: poll spacing after a zero read, hold-off after success with data.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TW'(GAP_CYC);
        if ((state == S_PRE_RD || state == S_POST_RD) && acc && resp_zero && !last_poll)
            tmr_load = 1'b1;
        if (state == S_POST_RD && acc && !resp_zero && resp_cls == ST_OK && want_q) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(RB_CYC);
        end
    end

    // Sequencer state, request capture, poll counting and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            msg_q    <= '0;
            arg_q    <= '0;
            want_q   <= 1'b0;
            alt_q    <= 1'b0;
            poll_cnt <= '0;
            status_q <= ST_OK;
            data_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_start) begin
                    msg_q    <= req_msg;
                    arg_q    <= req_arg;
                    want_q   <= req_want_data;
                    alt_q    <= req_alt_port;
                    poll_cnt <= '0;
                    status_q <= ST_OK;
                    data_q   <= '0;
                    state    <= S_PRE_RD;
                end
                S_PRE_RD: if (acc) begin
                    if (!resp_zero) begin
                        poll_cnt <= '0;
                        state    <= S_CLR_WR;
                    end else if (last_poll) begin
                        status_q <= ST_TIMEOUT;
                        state    <= S_FINISH;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= S_PRE_GAP;
                    end
                end
                S_PRE_GAP: if (tmr_expired) state <= S_PRE_RD;
                S_CLR_WR:  if (acc) state <= S_ARG_WR;
                S_ARG_WR:  if (acc) state <= S_MSG_WR;
                S_MSG_WR:  if (acc) state <= S_POST_RD;
                S_POST_RD: if (acc) begin
                    if (!resp_zero) begin
                        status_q <= resp_cls;
                        state    <= (resp_cls == ST_OK && want_q) ? S_HOLD : S_FINISH;
                    end else if (last_poll) begin
                        status_q <= ST_TIMEOUT;
                        state    <= S_FINISH;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= S_POST_GAP;
                    end
                end
                S_POST_GAP: if (tmr_expired) state <= S_POST_RD;
                S_HOLD:     if (tmr_expired) state <= S_DATA_RD;
                S_DATA_RD: if (acc) begin
                    data_q <= bus_rdata;
                    state  <= S_FINISH;
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign req_busy   = (state != S_IDLE);
    assign req_done   = (state == S_FINISH);
    assign req_status = status_q;
    assign req_data   = data_q;

    // Checker state: offset of the last accepted write, for the order property.
    logic [OFS_W-1:0] last_wr_ofs;
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_wr_ofs <= '0;
        else if (bus_valid && bus_ready && bus_write)
            last_wr_ofs <= bus_addr;
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> !req_done);

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |-> req_busy);

    assert_data_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_status != 3'(ST_OK)) |-> (req_data == 32'd0));

    assert_bus_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    assert_msg_after_arg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && bus_addr == msg_ofs) |-> (last_wr_ofs == arg_ofs));

    assert_arg_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_write && bus_addr == arg_ofs) |-> (last_wr_ofs == resp_ofs));

endmodule

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;

    localparam int CPU   = 2;
    localparam int GUS   = 3;
    localparam int LIM   = 5;
    localparam int RBUS  = 10;
    localparam int GAP   = GUS * CPU;
    localparam int RB    = RBUS * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [7:0]  req_msg = '0;
    logic [31:0] req_arg = '0;
    logic        req_want_data = 1'b0;
    logic        req_alt_port = 1'b0;
    logic        req_busy, req_done;
    logic [2:0]  req_status;
    logic [31:0] req_data;
    logic        bus_valid, bus_write;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_rdata = '0;

    mbox_cmd_seq #(
        .CYC_PER_US(CPU), .POLL_GAP_US(GUS), .POLL_LIMIT(LIM), .READBACK_US(RBUS)
    ) i_mbox_cmd_seq (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Responder model and access log.
    int          lat = 0, lat_cnt = 0;
    int          pre_left = 0, post_left = 0;
    logic [31:0] resp_code = 32'h1, ret_val = '0;
    bit          msg_seen = 0;
    int          nlog = 0;
    bit          lg_wr[64];
    logic [11:0] lg_addr[64];
    logic [31:0] lg_data[64];
    int          lg_cyc[64];

    function automatic bit is_resp(logic [11:0] a);
        return a == 12'h980 || a == 12'hA80;
    endfunction
    function automatic bit is_arg(logic [11:0] a);
        return a == 12'h9BC || a == 12'hA88;
    endfunction
    function automatic bit is_msg(logic [11:0] a);
        return a == 12'h538 || a == 12'hA20;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
            lat_cnt = 0;
        end else if (bus_ready) begin
            bus_ready = 1'b0;
        end else if (bus_valid) begin
            if (lat_cnt < lat) lat_cnt++;
            else begin
                lat_cnt = 0;
                bus_ready = 1'b1;
                bus_rdata = '0;
                if (!bus_write && is_resp(bus_addr)) begin
                    if (!msg_seen) begin
                        if (pre_left > 0) pre_left--; else bus_rdata = 32'h1;
                    end else begin
                        if (post_left > 0) post_left--; else bus_rdata = resp_code;
                    end
                end else if (!bus_write && is_arg(bus_addr)) begin
                    bus_rdata = ret_val;
                end else if (bus_write && is_msg(bus_addr)) begin
                    msg_seen = 1;
                end
                if (nlog < 64) begin
                    lg_wr[nlog]   = bus_write;
                    lg_addr[nlog] = bus_addr;
                    lg_data[nlog] = bus_write ? bus_wdata : bus_rdata;
                    lg_cyc[nlog]  = cyc;
                end
                nlog++;
            end
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [31:0] got_status, got_data;

    // Launch one command and wait for done; stray start while busy when extra set.
    task automatic run_cmd(bit alt, logic [7:0] m, logic [31:0] a, bit want,
                           int pre, int post, logic [31:0] code, bit extra);
        int t;
        @(negedge clk);
        pre_left = pre; post_left = post; resp_code = code; msg_seen = 0;
        nlog = 0;
        req_alt_port = alt; req_msg = m; req_arg = a; req_want_data = want;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(req_busy == 1'b1, "R9", "busy after start", req_busy, 1);
        if (extra) begin
            repeat (3) @(negedge clk);
            req_msg = 8'h77; req_arg = 32'h0BAD; req_alt_port = ~alt;
            req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        t = 0;
        while (!req_done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(req_done == 1'b1, "R10", "done seen", req_done, 1);
        got_status = 32'(req_status);
        got_data = req_data;
        @(negedge clk);
        chk(req_done == 1'b0, "R10", "done one cycle", req_done, 0);
        chk(req_busy == 1'b0, "R9", "idle after done", req_busy, 0);
        repeat (4) @(negedge clk);
    endtask

    // Compare the access log with the expected exchange.
    task automatic check_log(bit alt, logic [7:0] m, logic [31:0] a, bit want,
                             int pre, int post, logic [31:0] code, bit pre_to, bit post_to,
                             logic [2:0] exp_st, logic [31:0] exp_d);
        logic [11:0] r_ofs = alt ? 12'hA80 : 12'h980;
        logic [11:0] a_ofs = alt ? 12'hA88 : 12'h9BC;
        logic [11:0] m_ofs = alt ? 12'hA20 : 12'h538;
        int npre  = pre_to ? LIM : pre + 1;
        int npost = pre_to ? 0 : (post_to ? LIM : post + 1);
        int nwr   = pre_to ? 0 : 3;
        bit rd    = !pre_to && !post_to && code == 32'h1 && want;
        int exp_n = npre + nwr + npost + (rd ? 1 : 0);
        int i = 0;
        chk(nlog == exp_n, "R5", "access count", nlog, exp_n);
        if (nlog == exp_n) begin
            for (int k = 0; k < npre; k++) begin
                chk(!lg_wr[i] && lg_addr[i] == r_ofs, "R2", "pre-poll read", lg_addr[i], r_ofs);
                if (k > 0)
                    chk(lg_cyc[i] - lg_cyc[i-1] >= GAP, "R2", "poll spacing",
                        lg_cyc[i] - lg_cyc[i-1], GAP);
                i++;
            end
            if (nwr == 3) begin
                chk(lg_wr[i] && lg_addr[i] == r_ofs && lg_data[i] == 0, "R3", "clear write",
                    lg_addr[i], r_ofs);
                i++;
                chk(lg_wr[i] && lg_addr[i] == a_ofs && lg_data[i] == a, "R3", "arg write",
                    lg_data[i], a);
                i++;
                chk(lg_wr[i] && lg_addr[i] == m_ofs && lg_data[i] == {24'd0, m}, "R3",
                    "msg write", lg_data[i], {24'd0, m});
                i++;
            end
            for (int k = 0; k < npost; k++) begin
                chk(!lg_wr[i] && lg_addr[i] == r_ofs, "R4", "post-poll read", lg_addr[i], r_ofs);
                if (k > 0)
                    chk(lg_cyc[i] - lg_cyc[i-1] >= GAP, "R4", "poll spacing",
                        lg_cyc[i] - lg_cyc[i-1], GAP);
                i++;
            end
            if (rd) begin
                chk(!lg_wr[i] && lg_addr[i] == a_ofs, "R7", "readback addr", lg_addr[i], a_ofs);
                chk(lg_cyc[i] - lg_cyc[i-1] >= RB, "R7", "readback wait",
                    lg_cyc[i] - lg_cyc[i-1], RB);
            end
        end
        chk(got_status == 32'(exp_st), "R6", "status", got_status, 32'(exp_st));
        chk(got_data == exp_d, "R10", "data", got_data, exp_d);
    endtask

    task automatic t_reset;
        chk(req_busy == 0 && req_done == 0, "R1", "reset handshake", {req_busy, req_done}, 0);
        chk(bus_valid == 0, "R1", "reset bus idle", bus_valid, 0);
        chk(req_status == 0 && req_data == 0, "R1", "reset results", req_data, 0);
    endtask

    task automatic t_success_data;
        ret_val = 32'hCAFE_1234; lat = 0;
        run_cmd(0, 8'h9A, 32'h1111_2222, 1, 2, 1, 32'h01, 0);
        check_log(0, 8'h9A, 32'h1111_2222, 1, 2, 1, 32'h01, 0, 0, 3'd0, 32'hCAFE_1234);
    endtask

    task automatic t_success_nodata;
        run_cmd(0, 8'h05, 32'h0000_0042, 0, 0, 0, 32'h01, 0);
        check_log(0, 8'h05, 32'h0000_0042, 0, 0, 0, 32'h01, 0, 0, 3'd0, 32'h0);
    endtask

    task automatic t_alt_port_R8;
        ret_val = 32'h0BEE_F00D;
        run_cmd(1, 8'hBE, 32'h3, 1, 1, 2, 32'h01, 0);
        check_log(1, 8'hBE, 32'h3, 1, 1, 2, 32'h01, 0, 0, 3'd0, 32'h0BEE_F00D);
    endtask

    task automatic t_decode_R6;
        logic [31:0] codes[5] = '{32'hFC, 32'hFE, 32'hFD, 32'hFF, 32'h37};
        logic [2:0]  cls[5]   = '{3'd1, 3'd2, 3'd3, 3'd3, 3'd3};
        for (int k = 0; k < 5; k++) begin
            run_cmd(k[0], 8'h10 + 8'(k), 32'h100 + k, 1, 0, 1, codes[k], 0);
            check_log(k[0], 8'h10 + 8'(k), 32'h100 + k, 1, 0, 1, codes[k], 0, 0, cls[k], 32'h0);
        end
    endtask

    task automatic t_timeout_pre_R5;
        run_cmd(0, 8'h21, 32'h5, 1, 100, 0, 32'h01, 0);
        check_log(0, 8'h21, 32'h5, 1, 100, 0, 32'h01, 1, 0, 3'd4, 32'h0);
    endtask

    task automatic t_timeout_post_R5;
        run_cmd(1, 8'h22, 32'h6, 1, 0, 100, 32'h01, 0);
        check_log(1, 8'h22, 32'h6, 1, 0, 100, 32'h01, 0, 1, 3'd4, 32'h0);
    endtask

    task automatic t_edge_budget_R5;
        ret_val = 32'h5555_AAAA;
        run_cmd(0, 8'h23, 32'h7, 1, LIM - 1, LIM - 1, 32'h01, 0);
        check_log(0, 8'h23, 32'h7, 1, LIM - 1, LIM - 1, 32'h01, 0, 0, 3'd0, 32'h5555_AAAA);
    endtask

    task automatic t_ignore_start_R9;
        ret_val = 32'h1357_9BDF;
        run_cmd(0, 8'h44, 32'hABCD, 1, 1, 1, 32'h01, 1);
        check_log(0, 8'h44, 32'hABCD, 1, 1, 1, 32'h01, 0, 0, 3'd0, 32'h1357_9BDF);
        nlog = 0;
        repeat (20) @(negedge clk);
        chk(nlog == 0, "R9", "no access from ignored start", nlog, 0);
    endtask

    task automatic t_slow_bus_R11;
        lat = 3; ret_val = 32'h2468_ACE0;
        run_cmd(1, 8'h66, 32'h9999, 1, 1, 1, 32'h01, 0);
        check_log(1, 8'h66, 32'h9999, 1, 1, 1, 32'h01, 0, 0, 3'd0, 32'h2468_ACE0);
        lat = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_success_data();
        t_success_nodata();
        t_alt_port_R8();
        t_decode_R6();
        t_timeout_pre_R5();
        t_timeout_post_R5();
        t_edge_budget_R5();
        t_ignore_start_R9();
        t_slow_bus_R11();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule